// File: doc/BRIEF.md
# Serial-Bus EEPROM Slave Protocol Engine

This block is the two-wire serial-bus front end of a 128-byte EEPROM. It brings the open-drain clock and data lines into the system clock domain through a two-flop synchroniser and finds clock edges and bus START/STOP events. It then runs a slave protocol state machine that receives the device select byte and the word address, writes data bytes, and returns read data one bit per clock. It drives the data line low only, through an output enable.

A select byte carries a fixed device-type nibble, three bits compared with pin-strapped chip-enable inputs, and a read/write flag. A 7-bit address counter is shared by every kind of read and by writes, and it advances after each byte moved. Written bytes leave the block as a one-cycle strobe with address and data for an external write sequencer. The same strobe updates an internal 128 x 8 register-array model so that reads return what was written. While the sequencer reports busy, the engine ignores its own select code.

Top module: `eep_i2c_slave`

## Requirements
- R1: A select byte is received MSB first. Its bits 7..4 must be 1010 and bits 3..1 must equal chip_en_i[2], chip_en_i[1], chip_en_i[0]. Bit 0 is the direction: 1 for read, 0 for write. On a match the engine pulls SDA low for the 9th clock.
- R2: A select byte that does not match gets no acknowledge. Later clocks are ignored until the next START: no acknowledge and no write strobe.
- R3: While wr_busy_i is high, a matching select byte gets no acknowledge.
- R4: After a write select, the next byte is the word address, and its bit 7 is ignored. Each following data byte is acknowledged, emitted as a one-cycle wr_valid_o pulse with wr_addr_o/wr_data_o, and stored in the memory model.
- R5: A current-address read (START, select with bit 0 = 1) returns the byte at the address counter.
- R6: A random read (write select, address byte, repeated START, read select) returns the byte at the given address.
- R7: In a read, each byte the master acknowledges is followed by the byte at the next address. The counter wraps from 127 to 0.
- R8: The address counter increments after every byte read or written. Loading an address byte does not increment it.
- R9: When the master does not acknowledge a read byte, the engine releases SDA and keeps it released for any further clocks until START or STOP.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After STOP, clocked bytes without a new START get no acknowledge and cause no write.
- R11: The SDA output enable changes only while SCL is low, never during a high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| chip_en_i | input | 3 | Pin-strapped select bits |
| wr_busy_i | input | 1 | Write sequencer busy |
| sda_oe_o | output | 1 | Drive SDA low when 1 |
| wr_valid_o | output | 1 | Write byte strobe |
| wr_addr_o | output | 7 | Address of the written byte |
| wr_data_o | output | 8 | Written byte |

## Verification
The bench sweeps all eight chip-enable codes in the select byte and also tries a wrong type nibble. An engine that compared the wrong bits or their order would acknowledge a foreign device or ignore its own. It writes the whole array in one burst that starts at address 0x85. A design that kept bit 7 or failed to wrap would put bytes in the wrong place or report a wrong last address. It then reads 129 bytes in sequence to cross the 127-to-0 boundary, and checks the counter after the write burst, after a NACK and after an address-only write. An off-by-one increment shows up there as a shifted byte. It also clocks bytes after a NACK, after STOP, after a mismatched select and while busy. An engine that kept driving or kept listening would then pull SDA low or emit a write strobe.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_ADDR, ST_ADDR_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RACK
  } state_e;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_s, sda_s, scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;

  // R10: bus events are mutually exclusive
  assert_evt_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({scl_rise_o, scl_fall_o, start_o, stop_o}));
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];

  // R4: a write strobe lands in the array
  assert_mem_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/eep_proto_fsm.sv
module eep_proto_fsm
  import eep_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          sda_i,
  input  logic [2:0]    chip_en_i,
  input  logic          wr_busy_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          sda_oe_o,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  state_e        state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh, tx;
  logic [AW-1:0] addr;
  logic          rw, macked;
  logic          byte_done, in_dev_ack, in_rack;

  assign byte_done  = scl_fall_i && (cnt == CNT_FULL);
  assign in_dev_ack = (state == ST_DEV_ACK);
  assign in_rack    = (state == ST_RACK);
  assign rd_addr_o  = addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sh         <= '0;
      tx         <= '0;
      addr       <= '0;
      rw         <= 1'b0;
      macked     <= 1'b0;
      sda_oe_o   <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (start_i) begin
        state    <= ST_DEV;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_DEV, ST_ADDR, ST_WDAT: begin
            if (scl_rise_i) begin
              sh  <= {sh[DW-2:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (byte_done) begin
              if (state == ST_DEV) begin
                if (sh[7:4] == DEV_TYPE && sh[3:1] == chip_en_i && !wr_busy_i) begin
                  rw       <= sh[0];
                  sda_oe_o <= 1'b1;
                  state    <= ST_DEV_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_ADDR) begin
                addr     <= sh[AW-1:0];
                sda_oe_o <= 1'b1;
                state    <= ST_ADDR_ACK;
              end else begin
                wr_valid_o <= 1'b1;
                wr_addr_o  <= addr;
                wr_data_o  <= sh;
                addr       <= addr + 1'b1;
                sda_oe_o   <= 1'b1;
                state      <= ST_WDAT_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall_i) begin
              cnt <= '0;
              if (rw) begin
                tx       <= {rd_data_i[DW-2:0], 1'b0};
                sda_oe_o <= ~rd_data_i[DW-1];
                state    <= ST_RDAT;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= ST_ADDR;
              end
            end
          end
          ST_ADDR_ACK, ST_WDAT_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              cnt      <= '0;
              state    <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_fall_i) begin
              if (cnt == CNT_LAST) begin
                sda_oe_o <= 1'b0;
                addr     <= addr + 1'b1;
                cnt      <= '0;
                state    <= ST_RACK;
              end else begin
                sda_oe_o <= ~tx[DW-1];
                tx       <= {tx[DW-2:0], 1'b0};
                cnt      <= cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              macked <= ~sda_i;
            end else if (scl_fall_i) begin
              if (macked) begin
                tx       <= {rd_data_i[DW-2:0], 1'b0};
                sda_oe_o <= ~rd_data_i[DW-1];
                state    <= ST_RDAT;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: acknowledge only a select byte with matching type and chip bits
  assert_sel_match_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_dev_ack) |-> ($past(sh[7:4]) == DEV_TYPE && $past(sh[3:1]) == $past(chip_en_i)));
  // R3: no select acknowledge while the sequencer is busy
  assert_busy_nack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_dev_ack) |-> !$past(wr_busy_i));
  // R8: counter stands one past the byte just written
  assert_addr_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> addr == AW'(wr_addr_o + 1'b1));
  // R9: line released while waiting for the master's acknowledge
  assert_rack_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_rack |-> !sda_oe_o);
  // R11: drive only begins after an SCL falling edge
  assert_oe_on_fall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall_i));
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave #(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    chip_en_i,
  input  logic          wr_busy_i,
  output logic          sda_oe_o,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  logic          sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  eep_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  eep_proto_fsm #(.AW(AW), .DW(DW)) i_fsm (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(bus_start), .stop_i(bus_stop), .sda_i(sda_s),
    .chip_en_i, .wr_busy_i,
    .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .sda_oe_o, .wr_valid_o, .wr_addr_o, .wr_data_o
  );

  eep_mem #(.AW(AW), .DW(DW)) i_mem (
    .clk_i, .rst_ni,
    .we_i(wr_valid_o), .waddr_i(wr_addr_o), .wdata_i(wr_data_o),
    .raddr_i(rd_addr), .rdata_o(rd_data)
  );
endmodule

// File: tb/test_eep_i2c_slave.sv
module test_eep_i2c_slave;
  localparam int Q = 6;
  localparam logic [2:0] CE = 3'b101;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, m_sda = 1'b1;
  logic       busy = 1'b0;
  logic       sda_oe, wr_valid;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  wire        sda_line = m_sda & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0;
  logic [6:0] last_wa;
  logic [7:0] last_wd;
  int oe_hits = 0, oe_viol = 0;
  logic oe_watch = 1'b0, oe_prev = 1'b0;
  logic ack_bit;
  logic [7:0] rbyte;

  always #2 clk = ~clk;

  eep_i2c_slave i_eep_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .chip_en_i(CE), .wr_busy_i(busy),
    .sda_oe_o(sda_oe), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  always @(posedge clk) begin
    if (wr_valid) begin
      wr_cnt  <= wr_cnt + 1;
      last_wa <= wr_addr;
      last_wd <= wr_data;
    end
    if (oe_watch && sda_oe) oe_hits <= oe_hits + 1;
    if (rst_n && scl && (sda_oe !== oe_prev)) oe_viol <= oe_viol + 1;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + 11);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    scl = 1'b0; wq();
    m_sda = b;  wq();
    scl = 1'b1; wq();
    s = sda_line; wq();
  endtask

  task automatic do_start();
    scl = 1'b0; wq();
    m_sda = 1'b1; wq();
    scl = 1'b1; wq();
    m_sda = 1'b0; wq();
  endtask

  task automatic do_stop();
    scl = 1'b0; wq();
    m_sda = 1'b0; wq();
    scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~mack, s);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    int wc0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sda_oe == 1'b0, "R9 reset oe", sda_oe, 0);
    check(wr_valid == 1'b0, "R4 reset strobe", wr_valid, 0);

    // R1/R2: sweep chip bits, read direction
    for (int s = 0; s < 8; s++) begin
      do_start();
      send_byte({4'b1010, 3'(s), 1'b1}, ack_bit);
      check(ack_bit == (s == int'(CE)), "R1 R2 select ack", ack_bit, (s == int'(CE)));
      if (ack_bit) begin
        recv_byte(1'b0, rbyte);
        check(rbyte == 8'h00, "R5 read after reset", rbyte, 0);
      end
      do_stop();
    end
    do_start();
    send_byte({4'b1011, CE, 1'b1}, ack_bit);
    check(!ack_bit, "R2 wrong type nibble", ack_bit, 0);
    do_stop();

    // R4: full-array burst from 0x85 (bit 7 ignored, start at 5)
    do_start();
    send_byte({4'b1010, CE, 1'b0}, ack_bit);
    check(ack_bit, "R1 write select ack", ack_bit, 1);
    send_byte(8'h85, ack_bit);
    check(ack_bit, "R4 address ack", ack_bit, 1);
    for (int i = 0; i < 128; i++) begin
      send_byte(pat((5 + i) % 128), ack_bit);
      if (!ack_bit) check(1'b0, "R4 data ack", i, 1);
    end
    do_stop();
    check(wr_cnt == 128, "R4 strobe count", wr_cnt, 128);
    check(last_wa == 7'd4, "R4 R7 last write address", last_wa, 4);
    check(last_wd == pat(4), "R4 last write data", last_wd, pat(4));

    // R5/R8: counter at 5 after wrap
    do_start();
    send_byte({4'b1010, CE, 1'b1}, ack_bit);
    recv_byte(1'b0, rbyte);
    do_stop();
    check(rbyte == pat(5), "R5 R8 current read after burst", rbyte, pat(5));

    // R6/R7: random read from 0, 129 bytes across wrap
    do_start();
    send_byte({4'b1010, CE, 1'b0}, ack_bit);
    send_byte(8'h00, ack_bit);
    do_start();
    send_byte({4'b1010, CE, 1'b1}, ack_bit);
    check(ack_bit, "R6 read select after restart", ack_bit, 1);
    for (int i = 0; i < 129; i++) begin
      recv_byte(i < 128, rbyte);
      if (i == 0 || i == 127 || i == 128)
        check(rbyte == pat(i % 128), "R6 R7 sequential byte", rbyte, pat(i % 128));
      else if (rbyte != pat(i))
        check(1'b0, "R7 sequential byte", rbyte, pat(i));
    end
    // R9: further clocks after NACK
    oe_hits = 0; oe_watch = 1'b1;
    recv_byte(1'b0, rbyte);
    oe_watch = 1'b0;
    check(oe_hits == 0, "R9 released after NACK", oe_hits, 0);
    check(rbyte == 8'hFF, "R9 line idle after NACK", rbyte, 8'hFF);
    do_stop();

    do_start();
    send_byte({4'b1010, CE, 1'b1}, ack_bit);
    recv_byte(1'b0, rbyte);
    do_stop();
    check(rbyte == pat(1), "R8 counter after read wrap", rbyte, pat(1));

    // R2: mismatched write select, data ignored
    wc0 = wr_cnt;
    do_start();
    send_byte({4'b1010, 3'b011, 1'b0}, ack_bit);
    check(!ack_bit, "R2 foreign write select", ack_bit, 0);
    send_byte(8'h10, ack_bit);
    check(!ack_bit, "R2 no ack after mismatch", ack_bit, 0);
    send_byte(8'h5A, ack_bit);
    do_stop();
    check(wr_cnt == wc0, "R2 no strobe after mismatch", wr_cnt, wc0);

    // R3: busy blocks select
    busy = 1'b1;
    do_start();
    send_byte({4'b1010, CE, 1'b0}, ack_bit);
    check(!ack_bit, "R3 busy nack", ack_bit, 0);
    send_byte(8'h22, ack_bit);
    do_stop();
    busy = 1'b0;
    check(wr_cnt == wc0, "R3 no strobe while busy", wr_cnt, wc0);

    // R10/R8: address-only write, then bytes after STOP
    do_start();
    send_byte({4'b1010, CE, 1'b0}, ack_bit);
    send_byte(8'h10, ack_bit);
    do_stop();
    send_byte(8'h77, ack_bit);
    check(!ack_bit, "R10 no ack after STOP", ack_bit, 0);
    check(wr_cnt == wc0, "R10 no strobe after STOP", wr_cnt, wc0);
    do_start();
    send_byte({4'b1010, CE, 1'b1}, ack_bit);
    recv_byte(1'b0, rbyte);
    do_stop();
    check(rbyte == pat(16), "R8 R10 address byte sets counter", rbyte, pat(16));

    check(oe_viol == 0, "R11 oe change with SCL high", oe_viol, 0);
    finish_run();
  end
endmodule